// File: doc/BRIEF.md
# Standby Clock-Gating Controller

This block decides when two clock domains may be switched off to save power: the coherency unit's clock and the interrupt controller's clock. It watches activity inputs: a per-core flag that the core is in wait-for-interrupt or powerdown, a request-pending flag on the coherency slave port, a unit-busy flag, an interrupt-pending flag, and a per-core flag that a core is reading or writing the interrupt controller. From these it drives one clock-enable output per domain. These enables feed an external glitch-free clock gate, which is not part of this block.

Each domain has its own standby enable bit. A domain is gated only after its idle condition has held for a run of consecutive cycles, so it does not chatter. A wake event raises the clock enable combinationally, in the same cycle the event is seen. While the unit clock enable is low, the block forces the slave port's read-address, write-address and write-data ready outputs low, so no handshake can complete into a stopped domain. A status output per domain reports whether that domain is currently in its gated state.

Top module: `stb_clkgate_ctrl`

## Requirements
- R1: The unit domain enters its gated state only after IDLE_HOLD consecutive clock edges (default 2) at which all of these held: unit standby enabled, every core_wfi bit 1, slv_req 0 and unit_busy 0. From then on unit_gated is 1 and unit_clk_en is 0.
- R2: If any one of the R1 conditions is missing, the unit domain stays running: unit_gated is 0 and unit_clk_en is 1.
- R3: Each slave-port ready output equals its ready input while unit_clk_en is 1, and is 0 while unit_clk_en is 0.
- R4: While the unit domain is gated, any core_wfi bit at 0 or slv_req at 1 raises unit_clk_en in the same cycle. unit_gated clears at the next edge. unit_busy alone does not wake the domain.
- R5: The interrupt-controller domain enters its gated state after IDLE_HOLD consecutive edges with its standby enabled, irq_pend 0 and every core_ic_acc bit 0. If any of these is missing, it stays running.
- R6: While the interrupt-controller domain is gated, irq_pend at 1 or any core_ic_acc bit at 1 raises ic_clk_en in the same cycle. ic_gated clears at the next edge.
- R7: When a domain's standby enable is 0, that domain's clock enable is 1, and a gated domain wakes at once.
- R8: A single non-idle cycle restarts the consecutive-idle count, so idle, busy, idle does not gate the domain.
- R9: A synchronous active-high reset leaves both clock enables at 1 and both gated status outputs at 0.
- R10: unit_gated and ic_gated are 1 exactly while the matching domain is in its gated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_sb_en | input | 1 | Standby enable for the coherency unit clock |
| ic_sb_en | input | 1 | Standby enable for the interrupt controller clock |
| core_wfi | input | NUM_CORES | Per-core flag: in WFI or powerdown |
| core_ic_acc | input | NUM_CORES | Per-core flag: read or write to the interrupt controller in progress |
| slv_req | input | 1 | Request pending on the coherency slave port |
| unit_busy | input | 1 | Coherency unit has remaining activity |
| irq_pend | input | 1 | Interrupt pending |
| slv_arready_i | input | 1 | Read-address ready from the unit |
| slv_awready_i | input | 1 | Write-address ready from the unit |
| slv_wready_i | input | 1 | Write-data ready from the unit |
| unit_clk_en | output | 1 | Clock enable for the coherency unit |
| ic_clk_en | output | 1 | Clock enable for the interrupt controller |
| slv_arready_o | output | 1 | Read-address ready, forced low while the unit clock is off |
| slv_awready_o | output | 1 | Write-address ready, forced low while the unit clock is off |
| slv_wready_o | output | 1 | Write-data ready, forced low while the unit clock is off |
| unit_gated | output | 1 | Status: unit domain is gated |
| ic_gated | output | 1 | Status: interrupt controller domain is gated |

## Verification
The bench builds the block with NUM_CORES=2 and IDLE_HOLD=2. With these values the unit domain has 32 input combinations and the interrupt-controller domain has 16, so every combination is swept twice: once from the running state, to check gating entry, and once from the gated state, to check the same-cycle wake. The short hold window also makes it cheap to test that a single break in the idle run prevents gating. Expected values come from small reference functions in the bench.

// File: rtl/stb_pkg.sv
package stb_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_GATED = 1'b1
    } gate_st_e;

    typedef struct packed {
        logic idle;
        logic wake;
    } dom_cond_t;

    function automatic dom_cond_t make_cond(input logic idle, input logic wake);
        dom_cond_t c;
        c.idle = idle;
        c.wake = wake;
        return c;
    endfunction

endpackage

// File: rtl/stb_idle_detect.sv
module stb_idle_detect
    import stb_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 unit_sb_en,
    input  logic                 ic_sb_en,
    input  logic [NUM_CORES-1:0] core_wfi,
    input  logic [NUM_CORES-1:0] core_ic_acc,
    input  logic                 slv_req,
    input  logic                 unit_busy,
    input  logic                 irq_pend,
    output dom_cond_t            unit_cond,
    output dom_cond_t            ic_cond
);

    logic all_asleep;
    logic any_ic_acc;

    assign all_asleep = &core_wfi;
    assign any_ic_acc = |core_ic_acc;

    always_comb begin
        // unit_busy blocks entry but is not a wake source
        unit_cond = make_cond(unit_sb_en & all_asleep & ~slv_req & ~unit_busy,
                              ~unit_sb_en | ~all_asleep | slv_req);
        ic_cond   = make_cond(ic_sb_en & ~irq_pend & ~any_ic_acc,
                              ~ic_sb_en | irq_pend | any_ic_acc);
    end

endmodule

// File: rtl/stb_gate_fsm.sv
module stb_gate_fsm
    import stb_pkg::*;
#(
    parameter int IDLE_HOLD = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  dom_cond_t cond,
    output logic      clk_en,
    output logic      gated
);

    localparam int CW = (IDLE_HOLD < 2) ? 1 : $clog2(IDLE_HOLD);
    localparam logic [CW-1:0] LAST = CW'(IDLE_HOLD - 1);

    gate_st_e      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (cond.idle) begin
                    if (cnt_q == LAST) begin
                        state_d = ST_GATED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else begin
                    cnt_d = '0;
                end
            end
            ST_GATED: begin
                cnt_d = '0;
                if (cond.wake) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign gated  = (state_q == ST_GATED);
    assign clk_en = ~gated | cond.wake;

    // R1 / R5: gating is only entered right after an idle cycle
    assert_entry_after_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(gated) |-> $past(cond.idle));

    // R4 / R10: without a wake the gated state persists
    assert_hold_gated_R10: assert property (@(posedge clk) disable iff (rst)
        gated && !cond.wake |=> gated);

    // R4 / R6: a wake seen while gated leaves the gated state next edge
    assert_wake_exit_R4: assert property (@(posedge clk) disable iff (rst)
        gated && cond.wake |=> !gated);

endmodule

// File: rtl/stb_clkgate_ctrl.sv
module stb_clkgate_ctrl
    import stb_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int IDLE_HOLD = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 unit_sb_en,
    input  logic                 ic_sb_en,
    input  logic [NUM_CORES-1:0] core_wfi,
    input  logic [NUM_CORES-1:0] core_ic_acc,
    input  logic                 slv_req,
    input  logic                 unit_busy,
    input  logic                 irq_pend,
    input  logic                 slv_arready_i,
    input  logic                 slv_awready_i,
    input  logic                 slv_wready_i,
    output logic                 unit_clk_en,
    output logic                 ic_clk_en,
    output logic                 slv_arready_o,
    output logic                 slv_awready_o,
    output logic                 slv_wready_o,
    output logic                 unit_gated,
    output logic                 ic_gated
);

    localparam int NDOM = 2;

    dom_cond_t unit_cond, ic_cond;
    dom_cond_t conds [NDOM];
    logic [NDOM-1:0] en_v, gated_v;

    stb_idle_detect #(.NUM_CORES(NUM_CORES)) u_detect (
        .unit_sb_en  (unit_sb_en),
        .ic_sb_en    (ic_sb_en),
        .core_wfi    (core_wfi),
        .core_ic_acc (core_ic_acc),
        .slv_req     (slv_req),
        .unit_busy   (unit_busy),
        .irq_pend    (irq_pend),
        .unit_cond   (unit_cond),
        .ic_cond     (ic_cond)
    );

    assign conds[0] = unit_cond;
    assign conds[1] = ic_cond;

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        stb_gate_fsm #(.IDLE_HOLD(IDLE_HOLD)) u_fsm (
            .clk    (clk),
            .rst    (rst),
            .cond   (conds[d]),
            .clk_en (en_v[d]),
            .gated  (gated_v[d])
        );
    end

    assign unit_clk_en = en_v[0];
    assign ic_clk_en   = en_v[1];
    assign unit_gated  = gated_v[0];
    assign ic_gated    = gated_v[1];

    assign slv_arready_o = slv_arready_i & unit_clk_en;
    assign slv_awready_o = slv_awready_i & unit_clk_en;
    assign slv_wready_o  = slv_wready_i  & unit_clk_en;

    assert_ready_low_R3: assert property (@(posedge clk) disable iff (rst)
        !unit_clk_en |-> !slv_arready_o && !slv_awready_o && !slv_wready_o);

    assert_core_wake_R4: assert property (@(posedge clk) disable iff (rst)
        unit_gated && (!(&core_wfi) || slv_req) |-> unit_clk_en);

    assert_ic_wake_R6: assert property (@(posedge clk) disable iff (rst)
        irq_pend || (|core_ic_acc) |-> ic_clk_en);

    assert_sb_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!unit_sb_en |-> unit_clk_en) and (!ic_sb_en |-> ic_clk_en));

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> !unit_gated && !ic_gated && unit_clk_en && ic_clk_en);

endmodule

// File: tb/stb_clkgate_ctrl_bench.sv
`timescale 1ns/1ps
module stb_clkgate_ctrl_bench;

    localparam int NC = 2;

    logic clk = 0, rst = 1;
    logic unit_sb_en = 0, ic_sb_en = 0, slv_req = 0, unit_busy = 0, irq_pend = 0;
    logic [NC-1:0] core_wfi = '0, core_ic_acc = '0;
    logic ar_i = 1, aw_i = 1, w_i = 1;
    logic unit_clk_en, ic_clk_en, ar_o, aw_o, w_o, unit_gated, ic_gated;

    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    stb_clkgate_ctrl #(.NUM_CORES(NC), .IDLE_HOLD(2)) u_stb_clkgate_ctrl (
        .clk(clk), .rst(rst), .unit_sb_en(unit_sb_en), .ic_sb_en(ic_sb_en),
        .core_wfi(core_wfi), .core_ic_acc(core_ic_acc), .slv_req(slv_req),
        .unit_busy(unit_busy), .irq_pend(irq_pend),
        .slv_arready_i(ar_i), .slv_awready_i(aw_i), .slv_wready_i(w_i),
        .unit_clk_en(unit_clk_en), .ic_clk_en(ic_clk_en),
        .slv_arready_o(ar_o), .slv_awready_o(aw_o), .slv_wready_o(w_o),
        .unit_gated(unit_gated), .ic_gated(ic_gated)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // combo bits: [4]=en [3]=busy [2]=req [1:0]=wfi
    function automatic logic u_idle(input logic [4:0] c);
        return c[4] & (&c[1:0]) & ~c[2] & ~c[3];
    endfunction
    function automatic logic u_wake(input logic [4:0] c);
        return ~c[4] | ~(&c[1:0]) | c[2];
    endfunction
    // combo bits: [3]=en [2]=irq [1:0]=acc
    function automatic logic i_idle(input logic [3:0] c);
        return c[3] & ~c[2] & ~(|c[1:0]);
    endfunction

    task automatic set_u(input logic [4:0] c);
        unit_sb_en = c[4]; unit_busy = c[3]; slv_req = c[2]; core_wfi = c[1:0];
    endtask
    task automatic set_i(input logic [3:0] c);
        ic_sb_en = c[3]; irq_pend = c[2]; core_ic_acc = c[1:0];
    endtask

    initial begin : watchdog
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 0;
        #0;
        chk("R9 unit_clk_en", unit_clk_en, 1'b1);
        chk("R9 ic_clk_en", ic_clk_en, 1'b1);
        chk("R9 unit_gated", unit_gated, 1'b0);
        chk("R9 ic_gated", ic_gated, 1'b0);

        // unit domain, entry sweep from running
        for (int c = 0; c < 32; c++) begin
            set_u(5'b00000); tick();
            set_u(5'(c)); tick();
            chk("R8 no gate after one idle edge", unit_gated, 1'b0);
            tick();
            chk(u_idle(5'(c)) ? "R1 unit_gated" : "R2 unit_gated", unit_gated, u_idle(5'(c)));
            chk("R10 unit_clk_en", unit_clk_en, ~u_idle(5'(c)));
            chk("R3 arready", ar_o, ~u_idle(5'(c)));
            chk("R3 awready", aw_o, ~u_idle(5'(c)));
            chk("R3 wready", w_o, ~u_idle(5'(c)));
        end

        // unit domain, wake sweep from gated
        for (int c = 0; c < 32; c++) begin
            set_u(5'b00000); tick();
            set_u(5'b10011); tick(); tick();
            chk("R1 gated before wake", unit_gated, 1'b1);
            set_u(5'(c)); #1;
            chk(c[4] ? "R4 same-cycle wake" : "R7 sb off wakes", unit_clk_en, u_wake(5'(c)));
            chk("R3 ready follows enable", ar_o, u_wake(5'(c)));
            tick();
            chk("R4 gated after edge", unit_gated, ~u_wake(5'(c)));
        end

        // R8: idle, not idle, idle must not gate
        set_u(5'b00000); tick();
        set_u(5'b10011); tick();
        set_u(5'b11011); tick();
        set_u(5'b10011); tick();
        chk("R8 interrupted run", unit_gated, 1'b0);
        tick();
        chk("R8 gate after fresh run", unit_gated, 1'b1);
        ar_i = 0; aw_i = 0; w_i = 0;
        set_u(5'b10001); #1;
        chk("R3 ready passes input low", ar_o, 1'b0);
        ar_i = 1; aw_i = 1; w_i = 1; #1;
        chk("R3 ready passes input high", aw_o, 1'b1);
        set_u(5'b00000); tick();

        // interrupt controller domain
        for (int c = 0; c < 16; c++) begin
            set_i(4'b0000); tick();
            set_i(4'(c)); tick(); tick();
            chk("R5 ic_gated", ic_gated, i_idle(4'(c)));
            chk("R10 ic_clk_en", ic_clk_en, ~i_idle(4'(c)));
        end
        for (int c = 0; c < 16; c++) begin
            set_i(4'b0000); tick();
            set_i(4'b1000); tick(); tick();
            chk("R5 ic gated before wake", ic_gated, 1'b1);
            set_i(4'(c)); #1;
            chk(c[3] ? "R6 ic wake" : "R7 ic sb off", ic_clk_en, ~i_idle(4'(c)));
            tick();
            chk("R6 ic_gated after edge", ic_gated, i_idle(4'(c)));
        end

        // reset while gated
        set_i(4'b1000); set_u(5'b10011); tick(); tick();
        rst = 1; tick(); rst = 0;
        chk("R9 reset clears unit", unit_gated, 1'b0);
        chk("R9 reset clears ic", ic_gated, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule